// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store for lines that a direct-mapped first-level cache throws out when it replaces them. When the first-level cache misses, it presents the block address to this buffer in the same cycle as its own lookup. On a hit, the buffer returns the line and its dirty flag at once, so the first-level cache is refilled without going to the next memory level. The buffer lowers the miss penalty when several hot blocks map to the same direct-mapped index.

Lines enter through a valid/ready eviction stream. A transfer happens on a clock edge where both `evict_valid` and `evict_ready` are high. Once the source raises `evict_valid`, it holds the address, data and dirty flag stable until the transfer happens. Dirty lines that the buffer must discard leave through a valid/ready write-back stream. The buffer holds `wb_valid`, `wb_addr` and `wb_data` stable until `wb_ready` is seen high. The buffer lowers `evict_ready` only when storing the offered line would push out a dirty line while the write-back register still holds a line the next level has not accepted. The lookup port is a plain single-cycle request with a same-cycle answer.

The environment must not offer an eviction for a block address that is already stored in the buffer. A direct-mapped cache meets this rule, because every block it holds was first looked up here, and that lookup removed the block.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty: every lookup misses, `wb_valid` is 0 and `evict_ready` is 1.
- R2: A lookup whose address matches a stored line raises `lookup_hit` in the same cycle, with that line's data on `lookup_data` and its dirty flag on `lookup_dirty`. The line leaves the buffer at that clock edge, so a repeat lookup misses.
- R3: A lookup that matches nothing raises `lookup_miss` for that cycle only and changes no stored line.
- R4: When an accepted eviction and a lookup carry the same address in the same cycle, the lookup hits. It returns the incoming data and dirty flag, and that line is not stored.
- R5: When a lookup hits a stored line and a different line is accepted on the eviction port in the same cycle, the new line takes the freed entry. No other line is displaced and nothing is written back.
- R6: While any entry is empty, an accepted line goes into the lowest-numbered empty entry, and no stored line is displaced.
- R7: When all entries are full, an accepted line replaces the entry at a replacement pointer. The pointer starts at entry 0 after reset and advances by one, wrapping after entry DEPTH-1, only on such a replacement. From an empty buffer filled with no intervening hits, lines therefore leave in insertion order.
- R8: A displaced line with its dirty flag set is presented on `wb_addr`/`wb_data` with `wb_valid` high from the following cycle. A displaced clean line is dropped and produces no write-back.
- R9: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_addr` and `wb_data` stay unchanged.
- R10: `evict_ready` is low exactly when an offered line needs a dirty displacement while the write-back register holds a line with `wb_ready` low. The line is accepted in the first cycle where this no longer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | Eviction stream: a line is offered |
| evict_ready | output | 1 | Eviction stream: buffer accepts the offered line |
| evict_addr | input | ADDR_W | Block address of the evicted line |
| evict_data | input | DATA_W | Data of the evicted line |
| evict_dirty | input | 1 | Evicted line has been modified |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_addr | input | ADDR_W | Block address looked up |
| lookup_hit | output | 1 | Lookup found the line (same cycle) |
| lookup_miss | output | 1 | Lookup found nothing (same cycle) |
| lookup_data | output | DATA_W | Data of the hit line |
| lookup_dirty | output | 1 | Dirty flag of the hit line |
| wb_valid | output | 1 | Write-back stream: a dirty line is offered |
| wb_ready | input | 1 | Write-back stream: next level accepts |
| wb_addr | output | ADDR_W | Block address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
On every cycle the assertions check these properties:
- A lookup hit on a stored line removes exactly one entry.
- A swap keeps the occupancy unchanged.
- A miss or a same-cycle bypass leaves the stored set alone.
- Back-pressure appears only while the write-back register is stalled, and that register is never reloaded while stalled.
- A pending write-back holds steady.

Some behaviour depends on the history of the stored lines and only the bench scenarios can show it. This covers which entry a new line goes into, the FIFO order in which lines are displaced, and whether the displaced line was dirty, which decides if a write-back appears. The bench shows these by filling, swapping, overflowing and stalling the buffer against a behavioural model.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Where an accepted line is placed
  typedef enum logic [1:0] {
    SLOT_SWAP     = 2'd0,  // entry freed by a same-cycle lookup hit
    SLOT_FREE     = 2'd1,  // lowest empty entry
    SLOT_DISPLACE = 2'd2   // entry under the replacement pointer
  } slot_src_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 128
) (
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [DEPTH-1:0]             ent_dirty,
  input  logic [ADDR_W-1:0]            probe_addr,
  output logic [DEPTH-1:0]             hit_vec,
  output logic                         any_hit,
  output logic [$clog2(DEPTH)-1:0]     hit_idx,
  output logic [DATA_W-1:0]            hit_data,
  output logic                         hit_dirty
);
  localparam int IDXW = $clog2(DEPTH);

  // One comparator per entry, all in parallel
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_addr[g] == probe_addr);
  end

  assign any_hit = |hit_vec;

  // AND-OR selection; entries are unique so at most one bit is set
  always_comb begin
    hit_idx   = '0;
    hit_data  = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx = IDXW'(i);
      hit_data  = hit_data | (ent_data[i] & {DATA_W{hit_vec[i]}});
      hit_dirty = hit_dirty | (ent_dirty[i] & hit_vec[i]);
    end
  end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc
  import vc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0]         ent_valid,
  input  logic                     swap_hit,
  input  logic [$clog2(DEPTH)-1:0] swap_idx,
  input  logic                     advance,
  output logic [$clog2(DEPTH)-1:0] slot_idx,
  output slot_src_e                slot_src,
  output logic                     all_valid
);
  localparam int IDXW = $clog2(DEPTH);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  logic [IDXW-1:0] ptr_q;
  logic [IDXW-1:0] free_idx;

  assign all_valid = &ent_valid;

  // Lowest-numbered empty entry: scan downward so the lowest wins
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDXW'(i);
    end
  end

  always_comb begin
    if (swap_hit) begin
      slot_src = SLOT_SWAP;
      slot_idx = swap_idx;
    end else if (!all_valid) begin
      slot_src = SLOT_FREE;
      slot_idx = free_idx;
    end else begin
      slot_src = SLOT_DISPLACE;
      slot_idx = ptr_q;
    end
  end

  // Rotating FIFO pointer, moved only by a replacement
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/vc_wb_reg.sv
module vc_wb_reg #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              busy
);
  assign busy = wb_valid && !wb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        wb_valid <= 1'b0;
    else if (load)     wb_valid <= 1'b1;
    else if (wb_ready) wb_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      wb_addr <= load_addr;
      wb_data <= load_data;
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data)); // R9

  AST_WB_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R10
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vc_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  output logic              evict_ready,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              lookup_hit,
  output logic              lookup_miss,
  output logic [DATA_W-1:0] lookup_data,
  output logic              lookup_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int IDXW = $clog2(DEPTH);

  // Entry storage
  logic [DEPTH-1:0]             valid_q;
  logic [DEPTH-1:0]             dirty_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;

  logic [DEPTH-1:0]  hit_vec;
  logic              any_hit;
  logic [IDXW-1:0]   hit_idx;
  logic [DATA_W-1:0] hit_data;
  logic              hit_dirty;

  logic [IDXW-1:0] slot_idx;
  slot_src_e       slot_src;
  logic            all_valid;

  logic ent_hit, bypass, need_slot, displace, vic_dirty;
  logic fire, store, wb_load, wb_busy;

  vc_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .ent_valid (valid_q),
    .ent_addr  (addr_q),
    .ent_data  (data_q),
    .ent_dirty (dirty_q),
    .probe_addr(lookup_addr),
    .hit_vec   (hit_vec),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx),
    .hit_data  (hit_data),
    .hit_dirty (hit_dirty)
  );

  // Lookup side, answered in the request cycle
  assign ent_hit      = lookup_valid && any_hit;
  assign bypass       = lookup_valid && evict_valid && (evict_addr == lookup_addr);
  assign lookup_hit   = ent_hit || bypass;
  assign lookup_miss  = lookup_valid && !lookup_hit;
  assign lookup_data  = bypass ? evict_data  : hit_data;
  assign lookup_dirty = bypass ? evict_dirty : hit_dirty;

  // Eviction side
  assign need_slot = evict_valid && !bypass;
  assign displace  = need_slot && (slot_src == SLOT_DISPLACE);
  assign vic_dirty = dirty_q[slot_idx];

  assign evict_ready = !(displace && vic_dirty && wb_busy);
  assign fire        = evict_valid && evict_ready;
  assign store       = fire && !bypass;
  assign wb_load     = store && displace && vic_dirty;

  vc_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent_valid(valid_q),
    .swap_hit (ent_hit),
    .swap_idx (hit_idx),
    .advance  (store && displace),
    .slot_idx (slot_idx),
    .slot_src (slot_src),
    .all_valid(all_valid)
  );

  vc_wb_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wb_load),
    .load_addr(addr_q[slot_idx]),
    .load_data(data_q[slot_idx]),
    .wb_ready (wb_ready),
    .wb_valid (wb_valid),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .busy     (wb_busy)
  );

  // Valid bits: a hit frees its entry, a stored line claims its slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_hit && hit_vec[i]) valid_q[i] <= 1'b0;
      end
      if (store) valid_q[slot_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      addr_q[slot_idx]  <= evict_addr;
      data_q[slot_idx]  <= evict_data;
      dirty_q[slot_idx] <= evict_dirty;
    end
  end

  AST_HIT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    ent_hit && !store |=> $countones(valid_q) == $past($countones(valid_q)) - 1); // R2

  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_miss && !evict_valid |=> $stable(valid_q)); // R3

  AST_BYPASS_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && !ent_hit |=> $stable(valid_q)); // R4

  AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ent_hit && store |=> $stable($countones(valid_q))); // R5

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    store && !ent_hit && !(&valid_q) |=> $countones(valid_q) == $past($countones(valid_q)) + 1); // R6

  AST_DISPLACE_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    store && displace |=> &valid_q); // R7

  AST_BLOCK_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && !evict_ready |-> wb_valid && !wb_ready); // R10
endmodule

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
  localparam int DEPTH = 4;
  localparam int AW    = 12;
  localparam int DW    = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          evict_valid, evict_ready, evict_dirty;
  logic [AW-1:0] evict_addr;
  logic [DW-1:0] evict_data;
  logic          lookup_valid, lookup_hit, lookup_miss, lookup_dirty;
  logic [AW-1:0] lookup_addr;
  logic [DW-1:0] lookup_data;
  logic          wb_valid, wb_ready;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  victim_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_addr(evict_addr), .evict_data(evict_data), .evict_dirty(evict_dirty),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .lookup_hit(lookup_hit), .lookup_miss(lookup_miss),
    .lookup_data(lookup_data), .lookup_dirty(lookup_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // Behavioural model: a set of slots, a wrap counter, one pending write-back
  logic          m_v [DEPTH];
  logic [AW-1:0] m_a [DEPTH];
  logic [DW-1:0] m_d [DEPTH];
  logic          m_y [DEPTH];
  int            m_ptr;
  logic          m_wbv;
  logic [AW-1:0] m_wba;
  logic [DW-1:0] m_wbd;

  int    errors = 0;
  int    checks = 0;
  string req    = "R1";
  bit    done   = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [AW-1:0] la,
                      input logic ev, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                      input logic ey, input logic wr, output logic fired);
    int   k, freei, slot;
    logic found, byp, hit, allv, disp, exp_rdy;
    lookup_valid = lv; lookup_addr = la;
    evict_valid = ev; evict_addr = ea; evict_data = ed; evict_dirty = ey;
    wb_ready = wr;
    #2;
    k = -1;
    for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_a[i] == la && k < 0) k = i;
    found = lv && (k >= 0);
    byp   = lv && ev && (ea == la);
    hit   = found || byp;
    allv  = 1'b1; freei = -1;
    for (int i = 0; i < DEPTH; i++) if (!m_v[i]) begin allv = 1'b0; if (freei < 0) freei = i; end
    disp    = ev && !byp && !found && allv;
    exp_rdy = !(disp && m_y[m_ptr] && m_wbv && !wr);
    chk("evict_ready", 64'(evict_ready), 64'(exp_rdy));
    chk("lookup_hit",  64'(lookup_hit),  64'(hit));
    chk("lookup_miss", 64'(lookup_miss), 64'(lv && !hit));
    if (hit) begin
      chk("lookup_data",  64'(lookup_data),  byp ? 64'(ed) : 64'(m_d[k]));
      chk("lookup_dirty", 64'(lookup_dirty), byp ? 64'(ey) : 64'(m_y[k]));
    end
    chk("wb_valid", 64'(wb_valid), 64'(m_wbv));
    if (m_wbv) begin
      chk("wb_addr", 64'(wb_addr), 64'(m_wba));
      chk("wb_data", 64'(wb_data), 64'(m_wbd));
    end
    fired = ev && exp_rdy;
    @(posedge clk);
    if (found) m_v[k] = 1'b0;
    if (m_wbv && wr) m_wbv = 1'b0;
    if (fired && !byp) begin
      slot = found ? k : (!allv ? freei : m_ptr);
      if (disp && m_y[m_ptr]) begin
        m_wbv = 1'b1; m_wba = m_a[m_ptr]; m_wbd = m_d[m_ptr];
      end
      m_v[slot] = 1'b1; m_a[slot] = ea; m_d[slot] = ed; m_y[slot] = ey;
      if (disp) m_ptr = (m_ptr + 1) % DEPTH;
    end
    @(negedge clk);
  endtask

  task automatic ins(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic y, input logic wr);
    logic f;
    step(1'b0, '0, 1'b1, a, d, y, wr, f);
  endtask

  task automatic look(input logic [AW-1:0] a);
    logic f;
    step(1'b1, a, 1'b0, '0, '0, 1'b0, 1'b1, f);
  endtask

  task automatic idle(input logic wr);
    logic f;
    step(1'b0, '0, 1'b0, '0, '0, 1'b0, wr, f);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s watchdog: actual=hung expected=finished", req);
      summary();
      $finish;
    end
  end

  initial begin
    logic f;
    logic          pend;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    logic          py;
    logic [AW-1:0] nexta;
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_a[i] = '0; m_d[i] = '0; m_y[i] = 0; end
    m_ptr = 0; m_wbv = 0; m_wba = '0; m_wbd = '0;
    rst_n = 1'b0;
    lookup_valid = 0; lookup_addr = '0; evict_valid = 0; evict_addr = '0;
    evict_data = '0; evict_dirty = 0; wb_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    req = "R1"; look(12'h010); idle(1'b0);

    req = "R6"; ins(12'h101, 32'hA1A1_0001, 1'b1, 1'b1);
    ins(12'h102, 32'hA2A2_0002, 1'b0, 1'b1);
    ins(12'h103, 32'hA3A3_0003, 1'b1, 1'b1);
    ins(12'h104, 32'hA4A4_0004, 1'b0, 1'b1);
    req = "R3"; look(12'h777);
    req = "R2"; look(12'h102); look(12'h102);
    req = "R5"; step(1'b1, 12'h103, 1'b1, 12'h105, 32'hB5B5_0005, 1'b1, 1'b1, f);
    req = "R6"; ins(12'h106, 32'hB6B6_0006, 1'b1, 1'b1);
    req = "R8"; ins(12'h107, 32'hC7C7_0007, 1'b0, 1'b0);
    req = "R9"; idle(1'b0); idle(1'b0);
    req = "R10";
    step(1'b0, '0, 1'b1, 12'h108, 32'hC8C8_0008, 1'b0, 1'b0, f);
    step(1'b0, '0, 1'b1, 12'h108, 32'hC8C8_0008, 1'b0, 1'b0, f);
    step(1'b0, '0, 1'b1, 12'h108, 32'hC8C8_0008, 1'b0, 1'b1, f);
    idle(1'b1);
    req = "R8"; ins(12'h109, 32'hC9C9_0009, 1'b0, 1'b1); idle(1'b1);
    ins(12'h10A, 32'hCACA_000A, 1'b0, 1'b1); idle(1'b1);
    req = "R7"; look(12'h101); look(12'h107); look(12'h105);
    req = "R4"; step(1'b1, 12'h1AA, 1'b1, 12'h1AA, 32'hDDDD_00AA, 1'b1, 1'b1, f);
    look(12'h1AA);

    req = "R7";
    pend = 0; pa = '0; pd = '0; py = 0; nexta = 12'h200;
    for (int n = 0; n < 3000; n++) begin
      logic          lv, wr;
      logic [AW-1:0] la;
      if (!pend && ($urandom % 2 == 0)) begin
        pend = 1; pa = nexta; nexta = nexta + 1'b1; pd = $urandom; py = 1'($urandom);
      end
      lv = 1'($urandom);
      la = nexta - 12'(1 + ($urandom % 8));
      if (pend && ($urandom % 8 == 0)) la = pa;
      wr = ($urandom % 4) != 0;
      step(lv, la, pend, pa, pd, py, wr, f);
      if (f) pend = 0;
    end
    idle(1'b1);

    done = 1;
    summary();
    $finish;
  end
endmodule